// File: doc/BRIEF.md
# Rotating Banked Shared Memory

This block lets sixteen processing cores share one memory without a request arbiter. The storage is cut into sixteen single-port banks that are each one long (32 bits) wide. The low four bits of a long address pick the bank, and the upper bits pick the row inside that bank. A free-running slot counter turns a crossbar so that on every clock each bank is wired to exactly one core. The pairing moves on by one position per clock, so every core meets every bank once in each sixteen-cycle turn and two cores can never collide on a bank.

A core issues either a single-long read or write, or a block transfer that moves all sixteen longs of one row. A single access waits until its bank comes around and then finishes one cycle later. A block starts at whichever bank the core faces after one setup cycle and wraps around the banks, so it always takes the same number of cycles whatever the start slot. During block writes the block tells the core which long it is taking in that cycle, so the core can supply that long straight from its own register file. The core stays stalled (`busy`) from the cycle after its request until the cycle in which `done` pulses.

Top module: `rotmem_xbar`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, every port shows `busy`, `done`, `rsp_valid` and `xfer_act` low. This holds even if reset cuts a transfer short.
- R2: Address bits [3:0] select the bank and bits [AW-1:4] select the row. A read of any address returns the last long written to that address, whichever port wrote it.
- R3: The slot counter is 0 while reset is high and advances by one (mod 16) at every clock edge where reset is low. In a cycle with slot value s, port p is wired to bank (p + s) mod 16, and `xfer_idx` of p shows that bank.
- R4: A single access is accepted at the edge that ends its request cycle C0. It is issued in the first cycle Ci (1 <= i <= 16) in which its port faces the addressed bank. `done` pulses for one cycle in Ci+1, so it arrives 2 to 17 cycles after C0. For a read, `rsp_valid` and the read data are presented in that same cycle.
- R5: A block request (`req_block`=1) moves the 16 longs of row `req_addr[AW-1:4]` and ignores the low address bits. C1 is a setup cycle. The 16 accesses happen in C2..C17, starting at the bank faced in C2 and wrapping mod 16. `done` pulses in C18, exactly 18 cycles after C0.
- R6: A block read presents one beat per cycle in C3..C18. Each beat has `rsp_valid`=1, `rsp_idx` equal to the bank accessed in the previous cycle, and the long stored at {row, `rsp_idx`}.
- R7: A block write raises `xfer_act` in each of C2..C17. In each of those cycles it stores the `req_wdata` present in that cycle at {row, `xfer_idx`}. A single write stores the `req_wdata` captured at acceptance.
- R8: `busy` is high from C1 through the `done` cycle and low after it. A `req_valid` seen while `busy` is high is ignored: it does not start an access and does not change memory.
- R9: All sixteen ports may run transfers in the same cycles without interfering. No bank is accessed by more than one port in a cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NPORT | Request strobe, one bit per port |
| req_write | input | NPORT | 1 = write, 0 = read |
| req_block | input | NPORT | 1 = 16-long row transfer, 0 = single long |
| req_addr | input | NPORT*AW | Long address per port |
| req_wdata | input | NPORT*DW | Write data per port (live during block writes) |
| busy | output | NPORT | Port stalled by a transfer in progress |
| xfer_act | output | NPORT | Port accesses a bank in this cycle |
| xfer_idx | output | NPORT*BW | Bank currently wired to each port |
| rsp_valid | output | NPORT | Read data valid |
| rsp_idx | output | NPORT*BW | Bank (low address bits) of the read beat |
| rsp_rdata | output | NPORT*DW | Read data per port |
| done | output | NPORT | One-cycle completion pulse |

## Verification
On every cycle, the assertions check three things: no bank is touched by two ports at once, a block's completion lands exactly eighteen cycles into its busy run, and a single access completes within one full rotation with a one-cycle done pulse. Only the bench's scenarios can show that data reaches the right address. These scenarios cover the exact issue cycle that the slot counter implies, the beat order of a block read that wraps around the banks, and a request that is ignored because it arrived while the port was stalled. The reference memory is updated only when the bench completes a write, so crossed banks, wrong rows, or stale captures show up as data mismatches on later reads.

// File: rtl/rotmem_pkg.sv
package rotmem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SEEK,
    ST_BURST
  } port_state_e;
endpackage

// File: rtl/rotmem_bank.sv
module rotmem_bank #(
  parameter int DW    = 32,
  parameter int ROW_W = 4
) (
  input  logic             clk,
  input  logic             en,
  input  logic             we,
  input  logic [ROW_W-1:0] row,
  input  logic [DW-1:0]    wdata,
  output logic [DW-1:0]    rdata
);
  localparam int DEPTH = 1 << ROW_W;

  logic [DW-1:0] mem [DEPTH];

  // single-port, read-first; output register only moves when enabled
  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[row] <= wdata;
      rdata <= mem[row];
    end
  end
endmodule

// File: rtl/rotmem_port.sv
module rotmem_port
  import rotmem_pkg::*;
#(
  parameter int  NPORT   = 16,
  parameter int  DW      = 32,
  parameter int  ROW_W   = 4,
  parameter int  PORT_ID = 0,
  localparam int BW      = $clog2(NPORT),
  localparam int AW      = ROW_W + BW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [BW-1:0]       slot,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_block,
  input  logic [AW-1:0]       req_addr,
  input  logic [DW-1:0]       req_wdata,
  input  logic [NPORT*DW-1:0] bank_rd,
  output logic                mem_en,
  output logic                mem_we,
  output logic [ROW_W-1:0]    mem_row,
  output logic [DW-1:0]       mem_wdata,
  output logic                busy,
  output logic                xfer_act,
  output logic [BW-1:0]       xfer_idx,
  output logic                rsp_valid,
  output logic [BW-1:0]       rsp_idx,
  output logic [DW-1:0]       rsp_rdata,
  output logic                done
);
  localparam int CW = $clog2(NPORT + 3);

  port_state_e      state;
  logic             is_wr, is_blk, done_q, rd_q;
  logic [ROW_W-1:0] row_q;
  logic [BW-1:0]    bank_q, ridx_q, beat_q;
  logic [DW-1:0]    wd_q;
  logic [BW-1:0]    conn;
  logic             accept, issue, last_beat;

  // bank wired to this port in the current slot
  assign conn      = BW'(PORT_ID) + slot;
  assign accept    = (state == ST_IDLE) && !done_q && req_valid;
  assign issue     = (state == ST_BURST) || ((state == ST_SEEK) && (conn == bank_q));
  assign last_beat = (state == ST_BURST) && (beat_q == BW'(NPORT - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      done_q <= 1'b0;
      rd_q   <= 1'b0;
      is_wr  <= 1'b0;
      is_blk <= 1'b0;
      row_q  <= '0;
      bank_q <= '0;
      ridx_q <= '0;
      beat_q <= '0;
      wd_q   <= '0;
    end else begin
      done_q <= issue && ((state == ST_SEEK) || last_beat);
      rd_q   <= issue && !is_wr;
      if (issue) ridx_q <= conn;
      case (state)
        ST_IDLE: if (accept) begin
          is_wr  <= req_write;
          is_blk <= req_block;
          row_q  <= req_addr[AW-1:BW];
          bank_q <= req_addr[BW-1:0];
          wd_q   <= req_wdata;
          state  <= req_block ? ST_SETUP : ST_SEEK;
        end
        ST_SETUP: begin
          beat_q <= '0;
          state  <= ST_BURST;
        end
        ST_SEEK: if (issue) state <= ST_IDLE;
        ST_BURST: begin
          beat_q <= beat_q + BW'(1);
          if (last_beat) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign mem_en    = issue;
  assign mem_we    = issue && is_wr;
  assign mem_row   = row_q;
  assign mem_wdata = is_blk ? req_wdata : wd_q;
  assign busy      = (state != ST_IDLE) || done_q;
  assign xfer_act  = issue;
  assign xfer_idx  = conn;
  assign rsp_valid = rd_q;
  assign rsp_idx   = ridx_q;
  assign rsp_rdata = rd_q ? bank_rd[ridx_q*DW +: DW] : '0;
  assign done      = done_q;

  // length of the current stall, for the timing properties below
  logic [CW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst)       run_q <= '0;
    else if (busy) run_q <= run_q + CW'(1);
    else           run_q <= '0;
  end

  p_burst_len_r5: assert property (@(posedge clk) disable iff (rst)
    (done_q && is_blk) |-> (run_q == CW'(NPORT + 1)));
  p_seek_bound_r4: assert property (@(posedge clk) disable iff (rst)
    (done_q && !is_blk) |-> ((run_q >= CW'(1)) && (run_q <= CW'(NPORT))));
  p_done_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);
endmodule

// File: rtl/rotmem_xbar.sv
module rotmem_xbar
  import rotmem_pkg::*;
#(
  parameter int  NPORT = 16,
  parameter int  DW    = 32,
  parameter int  ROW_W = 4,
  localparam int BW    = $clog2(NPORT),
  localparam int AW    = ROW_W + BW
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    req_valid,
  input  logic [NPORT-1:0]    req_write,
  input  logic [NPORT-1:0]    req_block,
  input  logic [NPORT*AW-1:0] req_addr,
  input  logic [NPORT*DW-1:0] req_wdata,
  output logic [NPORT-1:0]    busy,
  output logic [NPORT-1:0]    xfer_act,
  output logic [NPORT*BW-1:0] xfer_idx,
  output logic [NPORT-1:0]    rsp_valid,
  output logic [NPORT*BW-1:0] rsp_idx,
  output logic [NPORT*DW-1:0] rsp_rdata,
  output logic [NPORT-1:0]    done
);
  logic [BW-1:0]       slot;
  logic [NPORT-1:0]    p_en, p_we;
  logic [ROW_W-1:0]    p_row [NPORT];
  logic [DW-1:0]       p_wd  [NPORT];
  logic [NPORT*DW-1:0] bank_rd_bus;

  // rotation: one step per clock, no arbitration
  always_ff @(posedge clk) begin
    if (rst) slot <= '0;
    else     slot <= slot + BW'(1);
  end

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    rotmem_port #(
      .NPORT(NPORT), .DW(DW), .ROW_W(ROW_W), .PORT_ID(g)
    ) u_port (
      .clk       (clk),
      .rst       (rst),
      .slot      (slot),
      .req_valid (req_valid[g]),
      .req_write (req_write[g]),
      .req_block (req_block[g]),
      .req_addr  (req_addr[g*AW +: AW]),
      .req_wdata (req_wdata[g*DW +: DW]),
      .bank_rd   (bank_rd_bus),
      .mem_en    (p_en[g]),
      .mem_we    (p_we[g]),
      .mem_row   (p_row[g]),
      .mem_wdata (p_wd[g]),
      .busy      (busy[g]),
      .xfer_act  (xfer_act[g]),
      .xfer_idx  (xfer_idx[g*BW +: BW]),
      .rsp_valid (rsp_valid[g]),
      .rsp_idx   (rsp_idx[g*BW +: BW]),
      .rsp_rdata (rsp_rdata[g*DW +: DW]),
      .done      (done[g])
    );
  end

  for (genvar b = 0; b < NPORT; b++) begin : g_bank
    logic [BW-1:0] sel;
    // port wired to bank b in this slot
    assign sel = BW'(b) - slot;

    rotmem_bank #(.DW(DW), .ROW_W(ROW_W)) u_bank (
      .clk   (clk),
      .en    (p_en[sel]),
      .we    (p_we[sel]),
      .row   (p_row[sel]),
      .wdata (p_wd[sel]),
      .rdata (bank_rd_bus[b*DW +: DW])
    );

    logic [NPORT-1:0] hit;
    for (genvar p = 0; p < NPORT; p++) begin : g_hit
      assign hit[p] = p_en[p] && (xfer_idx[p*BW +: BW] == BW'(b));
    end
    p_bank_single_r9: assert property (@(posedge clk) disable iff (rst)
      $onehot0(hit));
  end
endmodule

// File: tb/tb_rotmem_xbar.sv
module tb_rotmem_xbar;
  localparam int NP = 16, DW = 32, ROW_W = 4, BW = 4, AW = 8, NLONG = 256;
  localparam int NV = 12;
  // [47:44] port, [43:40] write flag, [39:32] address, [31:0] write data
  localparam logic [47:0] VEC [NV] = '{
    48'h0_1_00_11110000, 48'h5_1_3F_22220001, 48'hF_1_F0_33330002,
    48'h9_1_A7_44440003, 48'h2_0_3F_00000000, 48'hC_0_00_00000000,
    48'h3_0_F0_00000000, 48'h9_0_A7_00000000, 48'h1_1_11_55550004,
    48'h1_0_11_00000000, 48'hE_0_5B_00000000, 48'h6_0_C4_00000000
  };

  logic clk = 1'b0, rst = 1'b1;
  always #4 clk = ~clk;

  logic [NP-1:0]    req_valid = '0, req_write = '0, req_block = '0, blk_mode = '0;
  logic [AW-1:0]    a_addr   [NP];
  logic [DW-1:0]    a_wd     [NP];
  logic [ROW_W-1:0] blk_row  [NP];
  logic [7:0]       blk_salt [NP];
  logic [NP*AW-1:0] req_addr;
  logic [NP*DW-1:0] req_wdata;
  logic [NP-1:0]    busy, xfer_act, rsp_valid, done;
  logic [NP*BW-1:0] xfer_idx, rsp_idx;
  logic [NP*DW-1:0] rsp_rdata;
  logic [DW-1:0]    ref_mem [NLONG];
  logic [BW-1:0]    tb_slot;
  int checks = 0, fails = 0;

  function automatic logic [DW-1:0] pat(input logic [AW-1:0] a, input logic [7:0] salt);
    return {salt, 8'h3C, a, ~a};
  endfunction

  function automatic int m16(input int x);
    return ((x % NP) + NP) % NP;
  endfunction

  for (genvar g = 0; g < NP; g++) begin : g_drv
    assign req_addr[g*AW +: AW]  = a_addr[g];
    assign req_wdata[g*DW +: DW] = blk_mode[g] ?
      pat({blk_row[g], xfer_idx[g*BW +: BW]}, blk_salt[g]) : a_wd[g];
  end

  rotmem_xbar dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_block(req_block), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .xfer_act(xfer_act), .xfer_idx(xfer_idx), .rsp_valid(rsp_valid),
    .rsp_idx(rsp_idx), .rsp_rdata(rsp_rdata), .done(done)
  );

  // model of the rotation counter (R3)
  always_ff @(posedge clk) begin
    if (rst) tb_slot <= '0;
    else     tb_slot <= tb_slot + 4'd1;
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  task automatic idle_check(input string tag);
    check(busy == '0 && done == '0 && rsp_valid == '0 && xfer_act == '0, "R1", tag,
          {busy, done}, 32'h0);
  endtask

  task automatic single_op(input int p, input bit wr, input logic [7:0] addr,
                           input logic [31:0] wd);
    int s0, iexp, lat;
    bit seen, rv;
    logic [31:0] got;
    @(negedge clk);
    s0 = int'(tb_slot);
    req_valid[p] = 1'b1; req_write[p] = wr; req_block[p] = 1'b0;
    a_addr[p] = addr; a_wd[p] = wd; blk_mode[p] = 1'b0;
    @(negedge clk);
    req_valid[p] = 1'b0;
    seen = 0; lat = 0; rv = 0; got = '0;
    for (int k = 1; k <= 20 && !seen; k++) begin
      if (k > 1) @(negedge clk);
      if (done[p]) begin
        seen = 1; lat = k; rv = rsp_valid[p]; got = rsp_rdata[p*DW +: DW];
      end
    end
    iexp = m16(int'(addr[3:0]) - p - s0 - 1) + 1;
    check(lat == iexp + 1, "R3 R4", "single done latency", lat, iexp + 1);
    if (wr) begin
      check(rv == 1'b0, "R4", "no read data on write", rv, 0);
      ref_mem[addr] = wd;
    end else begin
      check(rv == 1'b1, "R4", "rsp_valid with done", rv, 1);
      check(got === ref_mem[addr], "R2", "single read data", got, ref_mem[addr]);
    end
  endtask

  task automatic block_op(input int p, input bit wr, input logic [3:0] row,
                          input logic [7:0] salt);
    int s0, beats;
    bit busy_ok, done_ok, act_ok, idx_ok, data_ok;
    logic [3:0] bi;
    @(negedge clk);
    s0 = int'(tb_slot);
    req_valid[p] = 1'b1; req_write[p] = wr; req_block[p] = 1'b1;
    a_addr[p] = {row, 4'h5}; blk_row[p] = row; blk_salt[p] = salt; blk_mode[p] = wr;
    @(negedge clk);
    req_valid[p] = 1'b0; req_block[p] = 1'b0;
    beats = 0; busy_ok = 1; done_ok = 1; act_ok = 1; idx_ok = 1; data_ok = 1;
    for (int k = 1; k <= 18; k++) begin
      if (k > 1) @(negedge clk);
      if (!busy[p]) busy_ok = 0;
      if (done[p] != (k == 18)) done_ok = 0;
      if (xfer_act[p] != (k >= 2 && k <= 17)) act_ok = 0;
      if (xfer_act[p] && xfer_idx[p*BW +: BW] != 4'(m16(p + s0 + k))) act_ok = 0;
      if (rsp_valid[p]) begin
        beats++;
        bi = 4'(m16(p + s0 + k - 1));
        if (k < 3 || rsp_idx[p*BW +: BW] != bi) idx_ok = 0;
        if (rsp_rdata[p*DW +: DW] !== ref_mem[{row, bi}]) data_ok = 0;
      end
    end
    check(done_ok, "R5", "block done exactly in C18", done[p], 1);
    check(busy_ok, "R8", "busy through C1..C18", busy[p], 1);
    check(act_ok, "R3 R7", "xfer_act/xfer_idx sequence", xfer_idx[p*BW +: BW], 4'(m16(p + s0 + 18)));
    if (wr) begin
      check(beats == 0, "R7", "no read beats on block write", beats, 0);
      for (int i = 0; i < NP; i++) ref_mem[{row, 4'(i)}] = pat({row, 4'(i)}, salt);
      blk_mode[p] = 1'b0;
    end else begin
      check(beats == NP, "R6", "block read beat count", beats, NP);
      check(idx_ok, "R6", "beat order from faced bank", rsp_idx[p*BW +: BW], 0);
      check(data_ok, "R6", "block read data", 0, 0);
    end
    @(negedge clk);
    check(busy[p] == 1'b0, "R8", "busy drops after done", busy[p], 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog run did not complete");
    finish_run();
  end

  initial begin
    bit all_ok, dn_ok;
    int lat [NP];
    logic [31:0] got [NP];
    logic [7:0]  ca [NP];
    int s0;
    for (int i = 0; i < NP; i++) begin
      a_addr[i] = '0; a_wd[i] = '0; blk_row[i] = '0; blk_salt[i] = '0;
    end
    for (int i = 0; i < NLONG; i++) ref_mem[i] = 'x;

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk); idle_check("outputs idle during reset");
    rst = 1'b0;
    @(negedge clk); idle_check("outputs idle after reset");

    // R9, R5, R7: every port block-writes its own row at once
    @(negedge clk);
    for (int p = 0; p < NP; p++) begin
      req_valid[p] = 1'b1; req_write[p] = 1'b1; req_block[p] = 1'b1;
      blk_row[p] = 4'(m16(p * 5 + 3)); blk_salt[p] = 8'hA1; blk_mode[p] = 1'b1;
      a_addr[p] = {blk_row[p], 4'h0};
    end
    @(negedge clk);
    req_valid = '0; req_block = '0;
    all_ok = 1; dn_ok = 1;
    for (int k = 1; k <= 18; k++) begin
      if (k > 1) @(negedge clk);
      if (busy != '1) all_ok = 0;
      if (done != ((k == 18) ? '1 : '0)) dn_ok = 0;
    end
    check(all_ok, "R9", "all ports busy together", busy, 32'hFFFF);
    check(dn_ok, "R5 R9", "all 16 blocks done in C18", done, 32'hFFFF);
    blk_mode = '0;
    for (int p = 0; p < NP; p++)
      for (int i = 0; i < NP; i++)
        ref_mem[{4'(m16(p * 5 + 3)), 4'(i)}] = pat({4'(m16(p * 5 + 3)), 4'(i)}, 8'hA1);
    @(negedge clk);

    // R6: block reads from several ports and slots
    block_op(0, 1'b0, 4'h3, 8'h00);
    block_op(11, 1'b0, 4'hD, 8'h00);
    // R7 then R6: rewrite a row from one port, read back from another
    block_op(3, 1'b1, 4'h6, 8'h7E);
    block_op(12, 1'b0, 4'h6, 8'h00);

    // R2, R3, R4: vector table of single accesses
    for (int v = 0; v < NV; v++)
      single_op(int'(VEC[v][47:44]), VEC[v][40], VEC[v][39:32], VEC[v][31:0]);

    // R9: concurrent single reads from all ports
    @(negedge clk);
    s0 = int'(tb_slot);
    for (int p = 0; p < NP; p++) begin
      ca[p] = {4'(p) ^ 4'h9, 4'(m16(p * 3))};
      req_valid[p] = 1'b1; req_write[p] = 1'b0; req_block[p] = 1'b0; a_addr[p] = ca[p];
      lat[p] = 0; got[p] = '0;
    end
    @(negedge clk);
    req_valid = '0;
    for (int k = 1; k <= 20; k++) begin
      if (k > 1) @(negedge clk);
      for (int p = 0; p < NP; p++)
        if (done[p]) begin lat[p] = k; got[p] = rsp_rdata[p*DW +: DW]; end
    end
    for (int p = 0; p < NP; p++) begin
      check(lat[p] == m16(int'(ca[p][3:0]) - p - s0 - 1) + 2, "R9 R4", "concurrent latency",
            lat[p], m16(int'(ca[p][3:0]) - p - s0 - 1) + 2);
      check(got[p] === ref_mem[ca[p]], "R9 R2", "concurrent read data", got[p], ref_mem[ca[p]]);
    end

    // R8: request while busy is ignored
    @(negedge clk);
    req_valid[7] = 1'b1; req_write[7] = 1'b0; req_block[7] = 1'b0; a_addr[7] = 8'h42;
    @(negedge clk);
    a_addr[7] = 8'h88; a_wd[7] = 32'hBAD0BAD0; req_write[7] = 1'b1;
    @(negedge clk);
    req_valid[7] = 1'b0;
    repeat (20) @(negedge clk);
    check(busy[7] == 1'b0, "R8", "no second access started", busy[7], 0);
    single_op(2, 1'b0, 8'h88, 32'h0);

    // R1: reset in the middle of a block
    @(negedge clk);
    req_valid[4] = 1'b1; req_write[4] = 1'b0; req_block[4] = 1'b1; a_addr[4] = 8'h20;
    @(negedge clk);
    req_valid[4] = 1'b0; req_block[4] = 1'b0;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    idle_check("reset aborts block");
    rst = 1'b0;
    @(negedge clk);
    idle_check("idle after mid-transfer reset");

    finish_run();
  end
endmodule